// File: doc/BRIEF.md
# Multiplexed-Bus Clock Register File

This block is a 128-byte register array on a shared byte-wide address/data bus. A bus cycle has two phases. First the host places an address on the bus and pulses the address strobe high. The block keeps the low seven bits when the strobe falls. Then the host runs a read or a write with the active-low read and write strobes, in the style where the two strobes are separate. Chip select must stay low for the whole data-phase pulse, or the access is dropped. An active-high power-fail input acts as a forced deselect.

The lowest fourteen addresses hold clock and control registers. The remaining 114 bytes are general-purpose storage. An active-low wipe input fills that storage with 0xFF one byte per clock and does not touch the low fourteen bytes. The reset input restarts only the bus control logic. It never changes the stored bytes.

All bus pins are asynchronous. They pass through two-flop synchronizers into the internal clock domain, so a strobe phase must last a few clock periods. The output bus is split into a data vector and an output-enable. A low enable means the pads are released to high impedance.

Top module: `mbus_rtc_regfile`

## Requirements
- R1: On each falling edge of the address strobe, bits 6..0 of the bus are kept as the access address. Bit 7 is ignored, and the address is kept whatever the level of chip select.
- R2: A write pulse that has chip select low throughout stores, at the kept address, the byte held on the bus late in the pulse. The store happens once, when the write strobe returns high.
- R3: While the read strobe and chip select are both low, the enable is high and the data output carries the byte at the kept address. The enable drops within a few clocks after the read strobe goes high.
- R4: If chip select is high at any point during a write pulse, nothing is stored. If chip select is high during a read, the enable stays low.
- R5: While power-fail is high, no byte is stored and the enable stays low.
- R6: Holding the wipe input low for at least 120 clocks sets every byte at addresses 14..127 to 0xFF. Addresses 0..13 keep their values.
- R7: After reset, the enable is low and every stored byte still holds its value from before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset of the control logic |
| bus_in | input | 8 | Shared address/data bus, as seen at the pads |
| bus_out | output | 8 | Read data driven to the pads |
| bus_oe | output | 1 | Pad drive enable; low means high impedance |
| astb | input | 1 | Address strobe, address kept on its falling edge |
| sel_n | input | 1 | Chip select, active low |
| rstb_n | input | 1 | Read strobe, active low |
| wstb_n | input | 1 | Write strobe, active low |
| wipe_n | input | 1 | Fill general-purpose bytes with 0xFF while low |
| pwr_fail | input | 1 | Supply-low indication, blocks every access |

## Verification
The assertions assume that every bus pin holds each level for at least three clocks, so that the synchronizers see every edge. They also assume that the bus carries its value before the strobe that uses it and keeps it until after that strobe. The bench drives every input on the falling clock edge and holds each phase for four or more clocks. It never overlaps a wipe with a bus write, and it changes power-fail only between bus cycles or in the middle of one that is meant to be blocked.

// File: rtl/mbus_rtc_pkg.sv
package mbus_rtc_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 7;
  localparam int CLK_REGS = 14;
  localparam int DEPTH    = 1 << ADDR_W;

  // True when an address falls in the general-purpose region
  function automatic logic is_user_byte(input logic [ADDR_W-1:0] a);
    return int'(a) >= CLK_REGS;
  endfunction

  // Next address for the wipe walker, wrapping back to the region start
  function automatic logic [ADDR_W-1:0] next_wipe(input logic [ADDR_W-1:0] a);
    if (int'(a) == DEPTH - 1) return ADDR_W'(CLK_REGS);
    return a + 1'b1;
  endfunction
endpackage

// File: rtl/mbus_rtc_sync.sv
module mbus_rtc_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RST_V;
    else        chain[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_V;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbus_rtc_busctl.sv
module mbus_rtc_busctl
  import mbus_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_s,
  input  logic              astb_s,
  input  logic              sel_n_s,
  input  logic              rstb_n_s,
  input  logic              wstb_n_s,
  input  logic              pwr_s,
  output logic [ADDR_W-1:0] addr_q,
  output logic              addr_load,
  output logic              wr_commit,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_drive
);
  logic astb_d, wstb_d, sel_ok;
  logic desel;

  assign desel     = sel_n_s | pwr_s;
  assign addr_load = astb_d & ~astb_s;
  assign wr_commit = wstb_n_s & ~wstb_d & sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      astb_d   <= 1'b0;
      wstb_d   <= 1'b1;
      sel_ok   <= 1'b0;
      addr_q   <= '0;
      wr_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      astb_d   <= astb_s;
      wstb_d   <= wstb_n_s;
      rd_drive <= ~rstb_n_s & ~desel;
      if (addr_load) addr_q <= bus_s[ADDR_W-1:0];
      if (!wstb_n_s) begin
        wr_data <= bus_s;
        if (wstb_d) sel_ok <= ~desel;
        else        sel_ok <= sel_ok & ~desel;
      end
    end
  end
endmodule

// File: rtl/mbus_rtc_store.sv
module mbus_rtc_store
  import mbus_rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe_act,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              wipe_we,
  output logic [ADDR_W-1:0] wipe_ptr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;

  assign wipe_we = wipe_act;

  always_comb begin
    if (wipe_act) begin
      we    = 1'b1;
      waddr = wipe_ptr;
      wdata = '1;
    end else begin
      we    = bus_we;
      waddr = bus_addr;
      wdata = bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wipe_ptr <= ADDR_W'(CLK_REGS);
    else if (wipe_act) wipe_ptr <= next_wipe(wipe_ptr);
  end

  assign rdata = mem[bus_addr];
endmodule

// File: rtl/mbus_rtc_regfile.sv
module mbus_rtc_regfile
  import mbus_rtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic              astb,
  input  logic              sel_n,
  input  logic              rstb_n,
  input  logic              wstb_n,
  input  logic              wipe_n,
  input  logic              pwr_fail
);
  localparam int CTL_W = 6;

  logic [DATA_W-1:0] bus_s;
  logic [CTL_W-1:0]  ctl_s;
  logic              astb_s, sel_n_s, rstb_n_s, wstb_n_s, wipe_n_s, pwr_s;
  logic [ADDR_W-1:0] addr_q, wipe_ptr;
  logic              addr_load, wr_commit, rd_drive, wipe_we;
  logic [DATA_W-1:0] wr_data, rdata, out_q;

  mbus_rtc_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_V('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s)
  );

  mbus_rtc_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_V(6'b011110)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pwr_fail, wipe_n, wstb_n, rstb_n, sel_n, astb}),
    .q(ctl_s)
  );

  assign {pwr_s, wipe_n_s, wstb_n_s, rstb_n_s, sel_n_s, astb_s} = ctl_s;

  mbus_rtc_busctl u_ctl (
    .clk(clk), .rst_n(rst_n), .bus_s(bus_s),
    .astb_s(astb_s), .sel_n_s(sel_n_s), .rstb_n_s(rstb_n_s),
    .wstb_n_s(wstb_n_s), .pwr_s(pwr_s),
    .addr_q(addr_q), .addr_load(addr_load), .wr_commit(wr_commit),
    .wr_data(wr_data), .rd_drive(rd_drive)
  );

  mbus_rtc_store u_store (
    .clk(clk), .rst_n(rst_n), .wipe_act(~wipe_n_s),
    .bus_we(wr_commit), .bus_addr(addr_q), .bus_wdata(wr_data),
    .wipe_we(wipe_we), .wipe_ptr(wipe_ptr), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= rdata;
  end

  assign bus_out = out_q;
  assign bus_oe  = rd_drive;
endmodule

// File: rtl/mbus_rtc_regfile_chk.sv
module mbus_rtc_regfile_chk
  import mbus_rtc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              addr_load,
  input logic [ADDR_W-1:0] addr_q,
  input logic              wr_commit,
  input logic              bus_oe,
  input logic              rstb_n_s,
  input logic              pwr_s,
  input logic              wipe_we,
  input logic [ADDR_W-1:0] wipe_ptr
);
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_load |=> $stable(addr_q)); // R1

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit); // R2

  AST_RELEASE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstb_n_s) |=> !bus_oe); // R3

  AST_PWR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(!pwr_s)); // R5

  AST_PWR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_s |=> !bus_oe); // R5

  AST_WIPE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    wipe_we |-> is_user_byte(wipe_ptr)); // R6
endmodule

bind mbus_rtc_regfile mbus_rtc_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_q(addr_q),
  .wr_commit(wr_commit), .bus_oe(bus_oe), .rstb_n_s(rstb_n_s),
  .pwr_s(pwr_s), .wipe_we(wipe_we), .wipe_ptr(wipe_ptr)
);

// File: tb/mbus_rtc_regfile_tb.sv
`timescale 1ns/1ps
module mbus_rtc_regfile_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic       astb = 1'b0, sel_n = 1'b1, rstb_n = 1'b1, wstb_n = 1'b1;
  logic       wipe_n = 1'b1, pwr_fail = 1'b0;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  mbus_rtc_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .astb(astb), .sel_n(sel_n), .rstb_n(rstb_n),
    .wstb_n(wstb_n), .wipe_n(wipe_n), .pwr_fail(pwr_fail)
  );

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [7:0] a);
    bus_in = a; astb = 1'b1; wait_n(4);
    astb = 1'b0; wait_n(4);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    addr_phase(a);
    bus_in = d; sel_n = 1'b0; wait_n(1);
    wstb_n = 1'b0; wait_n(5);
    wstb_n = 1'b1; wait_n(4);
    sel_n = 1'b1; wait_n(2);
  endtask

  task automatic data_read(output logic [7:0] d, output logic oe);
    sel_n = 1'b0; wait_n(1);
    rstb_n = 1'b0; wait_n(5);
    d = bus_out; oe = bus_oe;
    rstb_n = 1'b1; wait_n(1);
    sel_n = 1'b1; wait_n(4);
  endtask

  task automatic read_at(input logic [7:0] a, input string req, input logic [7:0] exp);
    logic [7:0] d; logic oe;
    addr_phase(a);
    data_read(d, oe);
    check(oe === 1'b1, req, oe, 1);
    check(d === exp, req, d, exp);
    check(bus_oe === 1'b0, {req, " release"}, bus_oe, 0);
  endtask

  task automatic t_reset_state();
    check(bus_oe === 1'b0, "R7 idle", bus_oe, 0);
  endtask

  task automatic t_basic_rw();
    do_write(8'd3, 8'hA5);
    do_write(8'd70, 8'h3C);
    read_at(8'd3, "R2 R3 ctrl byte", 8'hA5);
    read_at(8'd70, "R2 R3 ram byte", 8'h3C);
    do_write(8'd70, 8'hC7);
    read_at(8'd70, "R2 overwrite", 8'hC7);
  endtask

  task automatic t_bit7_ignored();
    do_write(8'h80 | 8'd30, 8'h5E);
    read_at(8'd30, "R1 bit7 ignored", 8'h5E);
  endtask

  task automatic t_addr_latch_no_sel();
    logic [7:0] d; logic oe;
    do_write(8'd40, 8'h44);
    do_write(8'd41, 8'h55);
    sel_n = 1'b1;
    addr_phase(8'd40);
    data_read(d, oe);
    check(oe === 1'b1 && d === 8'h44, "R1 latch while deselected", d, 8'h44);
  endtask

  task automatic t_sel_partial();
    logic [7:0] d; logic oe;
    do_write(8'd50, 8'h11);
    addr_phase(8'd50);
    bus_in = 8'hEE; sel_n = 1'b0; wait_n(1);
    wstb_n = 1'b0; wait_n(3);
    sel_n = 1'b1; wait_n(4);
    wstb_n = 1'b1; wait_n(5);
    read_at(8'd50, "R4 partial select write", 8'h11);
    addr_phase(8'd50);
    bus_in = 8'h99; wstb_n = 1'b0; wait_n(5);
    wstb_n = 1'b1; wait_n(5);
    rstb_n = 1'b0; wait_n(5);
    oe = bus_oe;
    rstb_n = 1'b1; wait_n(4);
    check(oe === 1'b0, "R4 read deselected", oe, 0);
    read_at(8'd50, "R4 write deselected", 8'h11);
  endtask

  task automatic t_power_fail();
    logic [7:0] d; logic oe;
    do_write(8'd60, 8'h2B);
    pwr_fail = 1'b1; wait_n(4);
    do_write(8'd60, 8'hD4);
    addr_phase(8'd60);
    data_read(d, oe);
    check(oe === 1'b0, "R5 no drive", oe, 0);
    pwr_fail = 1'b0; wait_n(4);
    read_at(8'd60, "R5 no store", 8'h2B);
  endtask

  task automatic t_wipe();
    do_write(8'd13, 8'h13);
    do_write(8'd0, 8'h07);
    do_write(8'd14, 8'h21);
    do_write(8'd127, 8'h7F);
    wipe_n = 1'b0; wait_n(130);
    wipe_n = 1'b1; wait_n(4);
    read_at(8'd13, "R6 ctrl kept 13", 8'h13);
    read_at(8'd0, "R6 ctrl kept 0", 8'h07);
    read_at(8'd14, "R6 first ram", 8'hFF);
    read_at(8'd127, "R6 last ram", 8'hFF);
    read_at(8'd70, "R6 mid ram", 8'hFF);
  endtask

  task automatic t_reset_keeps();
    do_write(8'd90, 8'hC3);
    do_write(8'd5, 8'h6A);
    rst_n = 1'b0; wait_n(3);
    check(bus_oe === 1'b0, "R7 oe in reset", bus_oe, 0);
    rst_n = 1'b1; wait_n(3);
    read_at(8'd90, "R7 ram kept", 8'hC3);
    read_at(8'd5, "R7 ctrl kept", 8'h6A);
  endtask

  initial begin : watchdog
    #1_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_n(3);
    t_reset_state();
    rst_n = 1'b1; wait_n(3);
    t_basic_rw();
    t_bit7_ignored();
    t_addr_latch_no_sel();
    t_sel_partial();
    t_power_fail();
    t_wipe();
    t_reset_keeps();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule